// File: doc/BRIEF.md
# Legacy INTx Interrupt Status and Mask Register

This block is the interrupt aggregation word of a PCI host bridge. It watches the four level-sensitive legacy interrupt lines (INTA to INTD) and records each asserted line in a pending flag. It gates those flags with per-line enables and drives one registered interrupt output toward the parent interrupt controller. The same 32-bit word also holds enable bits for eight bridge error events, a seven-bit bus-master priority field and a four-bit TRDY wait field. Software reaches all of these through a write port with byte strobes and a combinational read port.

Each line is tracked by a two-state machine. LINE_IDLE moves to LINE_PEND when the line is high and no acknowledge arrives in that cycle. LINE_PEND moves to LINE_IDLE on an acknowledge. An acknowledge always wins: a line that is still high is cleared by the acknowledge and set again on the following clock. Pending flags are write-one-to-clear, while every other field in the word is plain read/write. Software can therefore write back a word it has just read with zeros in the pending field and change only the enables, without losing pending lines.

Top module: `intx_irq_agg`

## Requirements
- R1: After reset the read word is 0x00000000 and `irq_out` is low.
- R2: A high level on `intx_in[i]` sets pending bit 28+i (bit 28 is INTA, bit 31 is INTD) at the next clock edge, whether or not the line is enabled.
- R3: Writing 1 to pending bit 28+i with strobe `reg_be[3]` set clears that flag. A 0 in that bit, or a write with `reg_be[3]` low, leaves the flag as it was.
- R4: A flag that is acknowledged while its line is still high reads 0 for one cycle and then reads 1 again.
- R5: Bits 25..22 enable lines INTD..INTA (bit 22 is INTA). `irq_out` is a register loaded with the OR over the lines of (pending AND enable), so it follows a change in pending or enable one clock later. A pending line whose enable is clear does not raise `irq_out`.
- R6: Bits 27, 26 and 21..16 are error enables. They pair with `err_evt[7:0]` as follows: bit 27 with err_evt[7] (command error), bit 26 with [6] (parity error), bit 21 with [5] (master abort received), bit 20 with [4] (target abort received), bit 19 with [3] (target abort sent), bit 18 with [2] (retry count of four), bit 17 with [1] (SERR received) and bit 16 with [0] (PERR received). A one-cycle pulse on an enabled event raises `irq_out` for exactly the following cycle. A pulse on a disabled event has no effect.
- R7: Bits 14..8 (priority for requesters 0 to 6) and bits 3..0 (TRDY wait) are read/write. Bits 15 and 7..4 always read 0.
- R8: Only the byte lanes whose `reg_be` bit is set are written. `reg_be[k]` covers bits 8k+7..8k.
- R9: A write of 0xF0000000 with `reg_be` = 4'b1100 clears all four pending flags and all four line enables in a single access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register word |
| intx_in | input | 4 | Level interrupt lines, bit 0 = INTA |
| err_evt | input | 8 | Error event pulses, mapping in R6 |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The interrupt lines are driven in several patterns: a single masked line, a single enabled line, two lines at once with only one of them acknowledged, and a line held high across its acknowledge. Together these show that pending tracking is separate from enabling, that the write-one-to-clear acts on each bit alone, and that level re-arming works. Writes are made with different strobe patterns and with zeros in the pending field, which shows that byte lanes and read/write fields do not disturb pending state. Error pulses are sent with their enable both set and clear, which shows that the one-cycle gating works and separates error paths from line paths.

// File: rtl/intx_pkg.sv
package intx_pkg;
    typedef enum logic {
        LINE_IDLE = 1'b0,
        LINE_PEND = 1'b1
    } line_state_t;

    localparam int WORD_W     = 32;
    localparam int NLINES     = 4;
    localparam int NERR       = 8;
    localparam int NREQ       = 7;
    localparam int WAITW      = 4;
    localparam int STS_LSB    = 28;
    localparam int LEN_LSB    = 22;
    localparam int CMD_EN_BIT = 27;
    localparam int PAR_EN_BIT = 26;
    localparam int BUS_EN_LSB = 16;
    localparam int PRI_LSB    = 8;
    localparam int WAIT_LSB   = 0;
    // plain read/write bits: 27..16, 14..8, 3..0
    localparam logic [WORD_W-1:0] RW_MASK = 32'h0FFF_7F0F;
endpackage

// File: rtl/intx_line_fsm.sv
module intx_line_fsm
    import intx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic ack,
    output logic pend
);
    line_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE: if (level_in && !ack) state_d = LINE_PEND;
            LINE_PEND: if (ack)              state_d = LINE_IDLE;
            default:                         state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == LINE_PEND);
    end

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !pend);
    assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (level_in && !ack) |=> pend);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !level_in) |=> !pend);
endmodule

// File: rtl/intx_cfg_fields.sv
module intx_cfg_fields
    import intx_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NB = W / 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [NB-1:0] be,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cfg_word,
    output logic [NLINES-1:0] line_en,
    output logic [NERR-1:0]   err_en
);
    logic [W-1:0] lane_mask;
    logic [W-1:0] wmask;
    logic [W-1:0] cfg_q;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        assign lane_mask[8*k +: 8] = {8{be[k]}};
    end

    assign wmask = we ? (lane_mask & RW_MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= (cfg_q & ~wmask) | (wdata & wmask);
    end

    assign cfg_word = cfg_q;
    assign line_en  = cfg_q[LEN_LSB +: NLINES];
    assign err_en   = {cfg_q[CMD_EN_BIT], cfg_q[PAR_EN_BIT], cfg_q[BUS_EN_LSB +: 6]};

    assert_lane2_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && be[2]) |=> (line_en[1:0] == $past(wdata[LEN_LSB +: 2])));
    assert_lane2_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && be[2]) |=> $stable(line_en[1:0]));
endmodule

// File: rtl/intx_irq_agg.sv
module intx_irq_agg
    import intx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [3:0]  intx_in,
    input  logic [7:0]  err_evt,
    output logic        irq_out
);
    logic [NLINES-1:0] ack;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] line_en;
    logic [NERR-1:0]   err_en;
    logic [WORD_W-1:0] cfg_word;
    logic              irq_q;

    assign ack = {NLINES{reg_we & reg_be[3]}} & reg_wdata[STS_LSB +: NLINES];

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        intx_line_fsm u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (intx_in[i]),
            .ack      (ack[i]),
            .pend     (pend[i])
        );
    end

    intx_cfg_fields u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .be       (reg_be),
        .wdata    (reg_wdata),
        .cfg_word (cfg_word),
        .line_en  (line_en),
        .err_en   (err_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (|(pend & line_en)) | (|(err_evt & err_en));
    end

    always_comb begin
        reg_rdata = cfg_word;
        reg_rdata[STS_LSB +: NLINES] = pend;
    end
    assign irq_out = irq_q;

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend & line_en) == '0) && ((err_evt & err_en) == '0)) |=> !irq_out);
    assert_line_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & line_en)) |=> irq_out);
    assert_err_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_evt & err_en)) |=> irq_out);
endmodule

// File: tb/intx_irq_agg_bench.sv
module intx_irq_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  intx_in = '0;
    logic [7:0]  err_evt = '0;
    logic        irq_out;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    intx_irq_agg u_intx_irq_agg (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intx_in(intx_in),
        .err_evt(err_evt), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        reg_we = 1'b1; reg_be = be; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_be = '0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1 word", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_masked_set();
        intx_in = 4'b0010; tick();
        chk("R2 INTB pending", {28'b0, reg_rdata[31:28]}, 32'h2);
        tick();
        chk("R5 masked no irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_enable();
        wr(4'b0100, 32'h0080_0000);
        chk("R5 enable read", reg_rdata, 32'h2080_0000);
        chk("R5 irq latency", {31'b0, irq_out}, 32'h0);
        tick();
        chk("R5 irq raised", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_ack();
        intx_in = 4'b0000;
        wr(4'b1000, 32'h0000_0000);
        chk("R3 zero leaves pending", reg_rdata, 32'h2080_0000);
        wr(4'b0111, 32'hF080_0000);
        chk("R3 lane3 off no clear", reg_rdata, 32'h2080_0000);
        wr(4'b1000, 32'h2000_0000);
        chk("R3 cleared", reg_rdata, 32'h0080_0000);
        tick();
        chk("R5 irq drops", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_level();
        intx_in = 4'b0001; tick();
        chk("R4 INTA set", {28'b0, reg_rdata[31:28]}, 32'h1);
        wr(4'b1000, 32'h1000_0000);
        chk("R4 acked", {28'b0, reg_rdata[31:28]}, 32'h0);
        tick();
        chk("R4 re-armed", {28'b0, reg_rdata[31:28]}, 32'h1);
        intx_in = 4'b0000;
        wr(4'b1000, 32'h1000_0000);
        tick();
        chk("R4 stays clear", {28'b0, reg_rdata[31:28]}, 32'h0);
    endtask

    task automatic t_multi();
        intx_in = 4'b1010; tick();
        intx_in = 4'b0000;
        chk("R2 two lines", {28'b0, reg_rdata[31:28]}, 32'hA);
        wr(4'b1000, 32'h8000_0000);
        chk("R3 only INTD cleared", {28'b0, reg_rdata[31:28]}, 32'h2);
        wr(4'b1000, 32'h2000_0000);
        chk("R3 INTB cleared", {28'b0, reg_rdata[31:28]}, 32'h0);
    endtask

    task automatic t_fields();
        wr(4'b1111, 32'h0000_0000);
        wr(4'b0011, 32'hFFFF_FFFF);
        chk("R7 low fields and reserved", reg_rdata, 32'h0000_7F0F);
        wr(4'b1111, 32'h0FFF_FFFF);
        chk("R7 full word", reg_rdata, 32'h0FFF_7F0F);
        wr(4'b0100, 32'h0000_0000);
        chk("R8 lane2 only", reg_rdata, 32'h0F00_7F0F);
    endtask

    task automatic t_halfword();
        wr(4'b1111, 32'h0FFF_7F0F);
        intx_in = 4'b1111; tick();
        intx_in = 4'b0000; tick();
        chk("R9 before", reg_rdata, 32'hFFFF_7F0F);
        chk("R9 irq before", {31'b0, irq_out}, 32'h1);
        wr(4'b1100, 32'hF000_0000);
        chk("R9 after", reg_rdata, 32'h0000_7F0F);
        tick();
        chk("R9 irq after", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_err();
        wr(4'b0100, 32'h0004_0000);
        err_evt = 8'b0000_0100; tick();
        err_evt = 8'b0;
        chk("R6 retry pulse", {31'b0, irq_out}, 32'h1);
        tick();
        chk("R6 one cycle", {31'b0, irq_out}, 32'h0);
        err_evt = 8'b1000_0000; tick();
        err_evt = 8'b0;
        chk("R6 disabled cmd", {31'b0, irq_out}, 32'h0);
        tick();
        chk("R6 disabled cmd later", {31'b0, irq_out}, 32'h0);
        wr(4'b1000, 32'h0800_0000);
        err_evt = 8'b1000_0000; tick();
        err_evt = 8'b0;
        chk("R6 enabled cmd", {31'b0, irq_out}, 32'h1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_masked_set();
        t_enable();
        t_ack();
        t_level();
        t_multi();
        t_fields();
        t_halfword();
        t_err();
        tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule